// File: doc/BRIEF.md
# Register-Stack Frame Cache with Automatic Spill and Fill

This block keeps the most recent subroutine frames of a program in a small circular register file and moves the oldest words to and from external memory on its own. The register file holds a fixed number of words. A frame starts at a frame base, has a length of 1 to 16 words, and is addressed by a 4-bit register index relative to that base. The physical slot wraps modulo the register-file depth.

A call opens a new frame. Its base is the caller's base plus the caller's length, minus an overlap count. The overlapping words are the caller's last words, so arguments written there become the callee's first registers without any copy. If the words from the oldest resident word up to the end of the new frame no longer fit, the block writes the oldest words out one by one to an external stack region. It then returns to idle. A return restores the caller's base and length, which the sequencer supplies from its saved link. If part of the caller's frame had been written out, the block reads those words back, newest first, until the whole caller frame is resident again. While a transfer is in progress the block signals busy and ignores new call, return and register-write requests.

Top module: `regstack_cache`

## Requirements
- R1: After a synchronous reset the frame base is 0, the frame length is 0, busy is low and no memory request is raised.
- R2: A call accepted in idle sets the frame length to the requested length (1 to 16) and the frame base to old base + old length − overlap, where the overlap is at most the old length. Words in the overlap keep the caller's values.
- R3: Register index r of the current frame reaches physical slot (base + r) mod depth. A write stores the value at the clock edge where the write enable is high. Read data for an index appears one clock after the index is presented.
- R4: After a call, the block spills exactly as many words as needed for (base + length − oldest resident position) to be at most the depth. It spills the oldest word first.
- R5: The k-th word ever spilled below the current resident region goes to byte address STACK_BASE + 4·k, where k counts from 0. The word written is the value that stack position held.
- R6: A return sets the base and length to the supplied caller values. It makes no memory access when the caller base is at or above the oldest resident position.
- R7: A return whose caller base lies below the oldest resident position reads words back in reverse order of spilling, with the address decreasing by 4 each time, until that position equals the caller base. The restored registers read back their original values.
- R8: Busy is high from the clock after a call or return is accepted until spilling and filling are complete. Call, return and register-write requests presented while busy have no effect.
- R9: A memory request keeps its address, direction and write data unchanged until the cycle in which it is acknowledged, and it is dropped on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_req | input | 1 | Open a new frame |
| call_len | input | 5 | Length of the new frame, 1..16 |
| call_ovl | input | 5 | Words shared with the caller's frame end |
| ret_req | input | 1 | Return to the caller frame |
| ret_fp | input | 16 | Caller frame base (absolute stack position) |
| ret_len | input | 5 | Caller frame length |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Frame-relative register index for writes |
| wr_data | input | 32 | Register write value |
| rd_idx | input | 4 | Frame-relative register index for reads |
| rd_data | output | 32 | Read value, one cycle after rd_idx |
| busy | output | 1 | Spill/fill in progress; requests ignored |
| cur_fp | output | 16 | Current absolute frame base |
| cur_len | output | 5 | Current frame length |
| mem_req | output | 1 | External word request |
| mem_we | output | 1 | 1 = spill write, 0 = fill read |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Spilled word |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Filled word |

## Verification
On every cycle the assertions check that a settled stack fits the register file with the oldest word at or below the frame base. They also check that spill writes happen only while the stack is overfull and fill reads only while the caller base is not resident, that a pending request holds still, that the frame cannot move while busy, and that the external pointer tracks the spilled word count. Only the bench scenarios can show the rest: the exact number of words moved per call or return, the addresses used, and that words survive a spill and a later fill through a wrapped physical index. The same holds for overlapping arguments reaching the callee and for requests made while busy being dropped.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CHECK = 3'd1,
    S_SRD   = 3'd2,
    S_SWR   = 3'd3,
    S_FILL  = 3'd4
  } rstk_state_t;
endpackage

// File: rtl/rstk_ram.sv
module rstk_ram #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_q,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_q <= mem[ra_addr];
    rb_q <= mem[rb_addr];
  end
endmodule

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
  import rstk_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          AW         = 6,
  parameter int          PW         = 16,
  parameter int          MAXF       = 16,
  parameter int          MAW        = 32,
  parameter logic [31:0] STACK_BASE = 32'h0000_1000,
  localparam int         LW         = $clog2(MAXF + 1),
  localparam int         IW         = $clog2(MAXF)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           call_req,
  input  logic [LW-1:0]  call_len,
  input  logic [LW-1:0]  call_ovl,
  input  logic           ret_req,
  input  logic [PW-1:0]  ret_fp,
  input  logic [LW-1:0]  ret_len,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic [IW-1:0]  rd_idx,
  output logic           busy,
  output logic [PW-1:0]  cur_fp,
  output logic [LW-1:0]  cur_len,
  output logic           mem_req,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  output logic           ram_we,
  output logic [AW-1:0]  ram_waddr,
  output logic [DW-1:0]  ram_wdata,
  output logic [AW-1:0]  ram_spill_addr,
  output logic [AW-1:0]  ram_user_addr,
  input  logic [DW-1:0]  ram_spill_q
);
  localparam int          DEPTH   = 1 << AW;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [MAW-1:0] WSTEP  = MAW'(4);

  rstk_state_t     state_q;
  logic [PW-1:0]   fp_q, bot_q;
  logic [LW-1:0]   len_q;
  logic [MAW-1:0]  esp_q;
  logic            mem_req_q, mem_we_q;
  logic [MAW-1:0]  mem_addr_q;
  logic [DW-1:0]   mem_wdata_q;

  logic [PW-1:0]   top, occ;
  logic            need_spill, need_fill;

  assign top        = fp_q + PW'(len_q);
  assign occ        = top - bot_q;
  assign need_spill = occ > DEPTH_P;
  assign need_fill  = bot_q > fp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      fp_q        <= '0;
      bot_q       <= '0;
      len_q       <= '0;
      esp_q       <= MAW'(STACK_BASE);
      mem_req_q   <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (call_req) begin
            fp_q    <= fp_q + PW'(len_q) - PW'(call_ovl);
            len_q   <= call_len;
            state_q <= S_CHECK;
          end else if (ret_req) begin
            fp_q    <= ret_fp;
            len_q   <= ret_len;
            state_q <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (need_spill) begin
            state_q <= S_SRD;
          end else if (need_fill) begin
            mem_req_q  <= 1'b1;
            mem_we_q   <= 1'b0;
            mem_addr_q <= esp_q - WSTEP;
            state_q    <= S_FILL;
          end else begin
            state_q <= S_IDLE;
          end
        end
        S_SRD: begin
          mem_req_q   <= 1'b1;
          mem_we_q    <= 1'b1;
          mem_addr_q  <= esp_q;
          mem_wdata_q <= ram_spill_q;
          state_q     <= S_SWR;
        end
        S_SWR: begin
          if (mem_ack) begin
            mem_req_q <= 1'b0;
            mem_we_q  <= 1'b0;
            bot_q     <= bot_q + PW'(1);
            esp_q     <= esp_q + WSTEP;
            state_q   <= S_CHECK;
          end
        end
        S_FILL: begin
          if (mem_ack) begin
            mem_req_q <= 1'b0;
            bot_q     <= bot_q - PW'(1);
            esp_q     <= esp_q - WSTEP;
            state_q   <= S_CHECK;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // Register-file write port: fill data has priority; user writes only in idle
  always_comb begin
    if (state_q == S_FILL && mem_ack) begin
      ram_we    = 1'b1;
      ram_waddr = bot_q[AW-1:0] - AW'(1);
      ram_wdata = mem_rdata;
    end else begin
      ram_we    = wr_en && (state_q == S_IDLE);
      ram_waddr = fp_q[AW-1:0] + AW'(wr_idx);
      ram_wdata = wr_data;
    end
  end

  assign ram_spill_addr = bot_q[AW-1:0];
  assign ram_user_addr  = fp_q[AW-1:0] + AW'(rd_idx);

  assign busy      = (state_q != S_IDLE);
  assign cur_fp    = fp_q;
  assign cur_len   = len_q;
  assign mem_req   = mem_req_q;
  assign mem_we    = mem_we_q;
  assign mem_addr  = mem_addr_q;
  assign mem_wdata = mem_wdata_q;

  AST_CALL_ARGS: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && call_req) |-> (call_len != '0 && call_len <= LW'(MAXF) && call_ovl <= len_q)); // R2
  AST_SETTLED_FIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> (occ <= DEPTH_P)); // R4
  AST_SPILL_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (mem_req_q && mem_we_q) |-> need_spill); // R4
  AST_ESP_TRACK: assert property (@(posedge clk) disable iff (rst)
    esp_q == MAW'(STACK_BASE) + (MAW'(bot_q) << 2)); // R5
  AST_SETTLED_RESIDENT: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE) |-> (bot_q <= fp_q)); // R7
  AST_FILL_WHEN_BELOW: assert property (@(posedge clk) disable iff (rst)
    (mem_req_q && !mem_we_q) |-> need_fill); // R7
  AST_FRAME_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE) |=> ($stable(fp_q) && $stable(len_q))); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_q && !mem_ack) |=> (mem_req_q && $stable(mem_addr_q) && $stable(mem_we_q) && $stable(mem_wdata_q))); // R9
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (mem_req_q && mem_ack) |=> !mem_req_q); // R9
endmodule

// File: rtl/regstack_cache.sv
module regstack_cache #(
  parameter int          DW         = 32,
  parameter int          AW         = 6,
  parameter int          PW         = 16,
  parameter int          MAXF       = 16,
  parameter int          MAW        = 32,
  parameter logic [31:0] STACK_BASE = 32'h0000_1000,
  localparam int         LW         = $clog2(MAXF + 1),
  localparam int         IW         = $clog2(MAXF)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           call_req,
  input  logic [LW-1:0]  call_len,
  input  logic [LW-1:0]  call_ovl,
  input  logic           ret_req,
  input  logic [PW-1:0]  ret_fp,
  input  logic [LW-1:0]  ret_len,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic [IW-1:0]  rd_idx,
  output logic [DW-1:0]  rd_data,
  output logic           busy,
  output logic [PW-1:0]  cur_fp,
  output logic [LW-1:0]  cur_len,
  output logic           mem_req,
  output logic           mem_we,
  output logic [MAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata
);
  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_spill_addr, ram_user_addr;
  logic [DW-1:0] ram_wdata, ram_spill_q;

  rstk_ctrl #(
    .DW(DW), .AW(AW), .PW(PW), .MAXF(MAXF), .MAW(MAW), .STACK_BASE(STACK_BASE)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .call_req(call_req), .call_len(call_len), .call_ovl(call_ovl),
    .ret_req(ret_req), .ret_fp(ret_fp), .ret_len(ret_len),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
    .busy(busy), .cur_fp(cur_fp), .cur_len(cur_len),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_spill_addr(ram_spill_addr), .ram_user_addr(ram_user_addr),
    .ram_spill_q(ram_spill_q)
  );

  rstk_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .ra_addr(ram_spill_addr), .ra_q(ram_spill_q),
    .rb_addr(ram_user_addr), .rb_q(rd_data)
  );
endmodule

// File: tb/tb_regstack_cache.sv
module tb_regstack_cache;
  localparam logic [31:0] SBASE = 32'h0000_1000;
  localparam int NV = 17;
  // {call?, len, ovl, exp_fp, exp_len, exp_spills, exp_fills}
  localparam logic [47:0] VEC [NV] = '{
    {1'b1, 5'd16, 5'd0, 16'd0,  5'd16, 8'd0,  8'd0},
    {1'b1, 5'd16, 5'd4, 16'd12, 5'd16, 8'd0,  8'd0},
    {1'b1, 5'd16, 5'd2, 16'd26, 5'd16, 8'd0,  8'd0},
    {1'b1, 5'd16, 5'd0, 16'd42, 5'd16, 8'd0,  8'd0},
    {1'b1, 5'd16, 5'd8, 16'd50, 5'd16, 8'd2,  8'd0},
    {1'b1, 5'd16, 5'd0, 16'd66, 5'd16, 8'd16, 8'd0},
    {1'b1, 5'd10, 5'd3, 16'd79, 5'd10, 8'd7,  8'd0},
    {1'b0, 5'd0,  5'd0, 16'd66, 5'd16, 8'd0,  8'd0},
    {1'b0, 5'd0,  5'd0, 16'd50, 5'd16, 8'd0,  8'd0},
    {1'b0, 5'd0,  5'd0, 16'd42, 5'd16, 8'd0,  8'd0},
    {1'b0, 5'd0,  5'd0, 16'd26, 5'd16, 8'd0,  8'd0},
    {1'b0, 5'd0,  5'd0, 16'd12, 5'd16, 8'd0,  8'd13},
    {1'b0, 5'd0,  5'd0, 16'd0,  5'd16, 8'd0,  8'd12},
    {1'b1, 5'd1,  5'd0, 16'd16, 5'd1,  8'd0,  8'd0},
    {1'b1, 5'd16, 5'd1, 16'd16, 5'd16, 8'd0,  8'd0},
    {1'b0, 5'd0,  5'd0, 16'd16, 5'd1,  8'd0,  8'd0},
    {1'b0, 5'd0,  5'd0, 16'd0,  5'd16, 8'd0,  8'd0}
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic        call_req = 0, ret_req = 0, wr_en = 0, mem_ack = 0;
  logic [4:0]  call_len = 0, call_ovl = 0, ret_len = 0;
  logic [15:0] ret_fp = 0;
  logic [3:0]  wr_idx = 0, rd_idx = 0;
  logic [31:0] wr_data = 0, mem_rdata = 0;
  logic [31:0] rd_data, mem_addr, mem_wdata;
  logic        busy, mem_req, mem_we;
  logic [15:0] cur_fp;
  logic [4:0]  cur_len;

  regstack_cache dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, spills = 0, fills = 0, bbot = 0, xfer = 0;
  bit done = 0;
  logic [31:0] lv  [256];
  logic [31:0] ext [256];
  logic [15:0] fs_fp  [32];
  logic [4:0]  fs_len [32];
  int sp = 0;
  logic [15:0] mfp = 0;
  logic [4:0]  mlen = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // External memory model with variable ack latency
  initial begin
    bit pend = 0; int hold = 0; logic [31:0] saddr = 0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        if (!pend) begin
          pend = 1; hold = xfer % 3; saddr = mem_addr; xfer++;
        end else begin
          chk(mem_addr == saddr, "R9 address held", mem_addr, saddr);
        end
        if (hold == 0) begin
          if (mem_we) begin
            chk(mem_addr == SBASE + 32'(4 * bbot), "R5 spill address", mem_addr, SBASE + 32'(4 * bbot));
            chk(mem_wdata == lv[bbot], "R5 spill data", mem_wdata, lv[bbot]);
            ext[bbot] = mem_wdata; bbot++; spills++;
          end else begin
            bbot--;
            chk(mem_addr == SBASE + 32'(4 * bbot), "R7 fill address", mem_addr, SBASE + 32'(4 * bbot));
            mem_rdata = ext[bbot]; fills++;
          end
          mem_ack = 1; pend = 0;
        end else hold--;
      end else mem_ack = 0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rdchk(input int r, input string req);
    rd_idx = 4'(r);
    @(negedge clk);
    chk(rd_data == lv[mfp + 16'(r)], req, rd_data, lv[mfp + 16'(r)]);
  endtask

  task automatic do_op(input int i);
    logic [47:0] v; bit is_call; logic [4:0] L, K, el; logic [15:0] efp; int esp, efl, s0, f0;
    v = VEC[i];
    {is_call, L, K, efp, el} = v[47:16];
    esp = int'(v[15:8]); efl = int'(v[7:0]);
    s0 = spills; f0 = fills;
    if (is_call) begin
      fs_fp[sp] = mfp; fs_len[sp] = mlen; sp++;
      call_len = L; call_ovl = K; call_req = 1;
    end else begin
      sp--;
      ret_fp = fs_fp[sp]; ret_len = fs_len[sp]; ret_req = 1;
    end
    @(negedge clk);
    call_req = 0; ret_req = 0;
    chk(busy == 1'b1, "R8 busy after accept", 32'(busy), 1);
    // requests presented while busy must be dropped
    ret_req = 1; ret_fp = 16'd7; ret_len = 5'd3;
    wr_en = 1; wr_idx = 0; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    ret_req = 0; wr_en = 0;
    wait_idle();
    mfp = efp; mlen = el;
    chk(cur_fp == efp, is_call ? "R2 call base" : "R6 return base", 32'(cur_fp), 32'(efp));
    chk(cur_len == el, is_call ? "R2 call length" : "R6 return length", 32'(cur_len), 32'(el));
    chk(spills - s0 == esp, "R4 spill count", 32'(spills - s0), 32'(esp));
    chk(fills - f0 == efl, is_call ? "R6 fill count" : "R7 fill count", 32'(fills - f0), 32'(efl));
    if (is_call) begin
      for (int r = 0; r < int'(K); r++) rdchk(r, "R2 overlap kept");
      for (int r = int'(K); r < int'(L); r++) begin
        wr_en = 1; wr_idx = 4'(r); wr_data = 32'hC0DE_0000 | 32'(i * 256 + r);
        lv[mfp + 16'(r)] = wr_data;
        @(negedge clk);
        wr_en = 0;
      end
    end
    for (int r = 0; r < int'(mlen); r++) rdchk(r, efl > 0 ? "R7 restored value" : "R3 frame readback R8");
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin lv[a] = 32'hBAD0_0000 | 32'(a); ext[a] = '0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cur_fp == 0, "R1 reset base", 32'(cur_fp), 0);
    chk(cur_len == 0, "R1 reset length", 32'(cur_len), 0);
    chk(busy == 0, "R1 reset busy", 32'(busy), 0);
    chk(mem_req == 0, "R1 reset request", 32'(mem_req), 0);
    for (int i = 0; i < NV; i++) do_op(i);
    // Directed: read latency — index change shows on rd_data only after a clock
    rd_idx = 0; @(negedge clk);
    rd_idx = 4'd5; #1;
    chk(rd_data == lv[mfp], "R3 read latency old", rd_data, lv[mfp]);
    @(negedge clk);
    chk(rd_data == lv[mfp + 16'd5], "R3 read latency new", rd_data, lv[mfp + 16'd5]);
    chk(bbot == 0 && mem_req == 0, "R7 all words resident", 32'(bbot), 0);
    finish_run();
  end
endmodule